// File: doc/BRIEF.md
# Quadrature Encoder Pulse Divider

This block takes the logic-level A, B and index (Z) channels of an incremental encoder. It samples them on a system clock and delivers three outputs. The A output is always the A channel divided by a programmable 8-bit denominator. The B output takes one of three roles, chosen by the mode. It can be the divided B channel. It can be a direction flag derived from the phase order of A and B. It can also be a registered copy of an external direction level that arrives on the B input. The index channel is never divided; it is only synchronized and registered.

Configuration arrives as a 12-wide vector of switch positions. A switch that is ON reads as logic 0, so the block inverts every position before decoding it. Position 1 is unused. Positions 2 and 3 select the mode. Position 4 is an active-low counter clear. Positions 5 to 12 hold the denominator, with position 5 as its least significant bit. The mode and the denominator are captured only while the clear is active. The user applies the clear after any configuration change and then releases it to run.

Top module: `qenc_divider`

## Requirements
- R1: `sw_on[i]` carries the switch position i+1, and 1 means ON, which reads as logic 0. The denominator N is the logical value of positions 12..5, with position 5 as bit 0. For example, positions 5..12 reading 1,0,1,0,1,0,1,0 give N = 85.
- R2: After `rst`, all three outputs are 0. While the clear is active (logical position 4 = 0), `out_a` and `out_b` are forced to 0 and all divide counters and the direction flag are zeroed.
- R3: The mode and N are taken from the switches only while the clear is active. Switch changes made while running have no effect until the next clear.
- R4: Mode 0 (logical position 2 = 0, position 3 = 0): `out_a` is A divided by N and `out_b` is B divided by N. Each channel has its own counter.
- R5: For N >= 2, a counter advances on each rising input edge and wraps after N edges. The output is 1 after the first floor(N/2) edges of each period and 0 after the rest.
- R6: With N = 1 the divided output copies its input, 3 clock edges behind the input.
- R7: With N = 0 the divided outputs stay at 0.
- R8: Mode 1 (position 2 = 0, position 3 = 1): at every rising edge of A, `out_b` takes the level of B at that moment (0 = A leads, 1 = B leads). It holds that value between A rising edges.
- R9: Mode 2 (position 2 = 1, position 3 ignored): `out_b` copies the B input with the same 3-edge latency as the A path, and `out_a` is divided A.
- R10: `out_z` copies `enc_z` 3 clock edges later in every mode, including while the clear is active.
- R11: Switch position 1 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_on | input | 12 | Switch positions 1..12 at bits 0..11; 1 = ON (logic 0) |
| enc_a | input | 1 | Encoder channel A |
| enc_b | input | 1 | Encoder channel B, or a direction level in mode 2 |
| enc_z | input | 1 | Encoder index channel |
| out_a | output | 1 | Divided A |
| out_b | output | 1 | Divided B, phase direction flag, or direction copy, depending on mode |
| out_z | output | 1 | Registered index |

## Verification
The hardest condition to reach from the ports is a switch change made while running that must not take effect. The divider has to be observed still dividing by the captured N while the switches already show another denominator. The stimulus captures N = 2, rewrites the switches to N = 5 without a clear, and then drives a pulse train whose expected waveform is distinct for the two values. A full period at N = 85 is also driven, using the worked bit pattern with the unused position toggled, so the wrap point far from small counts is exercised.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
    localparam int SW_W  = 12;
    localparam int DIV_W = 8;
    localparam int NCH   = 2;

    localparam int POS_P2  = 1;
    localparam int POS_P3  = 2;
    localparam int POS_RUN = 3;
    localparam int POS_DIV = 4;

    typedef enum logic [1:0] {
        QM_DIV_BOTH = 2'd0,
        QM_QUAD_DIR = 2'd1,
        QM_EXT_DIR  = 2'd2
    } qmode_e;

    typedef struct packed {
        logic             run;
        qmode_e           mode;
        logic [DIV_W-1:0] div;
    } qcfg_t;

    function automatic qcfg_t decode_sw(input logic [SW_W-1:0] sw_on);
        logic [SW_W-1:0] lv;
        qcfg_t c;
        lv    = ~sw_on;
        c.run = lv[POS_RUN];
        c.div = lv[POS_DIV +: DIV_W];
        if (lv[POS_P2])
            c.mode = QM_EXT_DIR;
        else if (lv[POS_P3])
            c.mode = QM_QUAD_DIR;
        else
            c.mode = QM_DIV_BOTH;
        return c;
    endfunction
endpackage

// File: rtl/qdiv_sync.sv
module qdiv_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qdiv_pulse_div.sv
module qdiv_pulse_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             lvl,
    input  logic             rise,
    input  logic [DIV_W-1:0] div,
    output logic             out_q
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;

    assign half = div >> 1;
    assign last = div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (div == '0) begin
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (div == DIV_W'(1)) begin
            cnt   <= '0;
            out_q <= lvl;
        end else if (rise) begin
            out_q <= (cnt < half);
            cnt   <= (cnt >= last) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qenc_divider.sv
module qenc_divider
    import qdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SW_W-1:0] sw_on,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            enc_z,
    output logic            out_a,
    output logic            out_b,
    output logic            out_z
);
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    logic [SW_W-1:0] sw_s;
    logic [2:0]      enc_s;
    logic [NCH-1:0]  lvl;
    logic [NCH-1:0]  lvl_prev;
    logic [NCH-1:0]  rise;
    logic [NCH-1:0]  div_out;
    qcfg_t           sw_cfg;
    qcfg_t           cfg_q;
    qmode_e          cur_mode;
    logic [DIV_W-1:0] cur_div;
    logic            clr_act;
    logic            a_rise;
    logic            dir_q;
    logic            ext_q;
    logic            z_q;

    qdiv_sync #(.WIDTH(SW_W)) u_sw_sync (
        .clk(clk), .rst(rst), .d(sw_on), .q(sw_s)
    );

    qdiv_sync #(.WIDTH(3)) u_enc_sync (
        .clk(clk), .rst(rst), .d({enc_z, enc_b, enc_a}), .q(enc_s)
    );

    assign sw_cfg   = decode_sw(sw_s);
    assign clr_act  = ~sw_cfg.run;
    assign cur_mode = cfg_q.mode;
    assign cur_div  = cfg_q.div;
    assign lvl      = enc_s[NCH-1:0];
    assign rise     = lvl & ~lvl_prev;
    assign a_rise   = rise[CH_A];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{run: 1'b1, mode: QM_DIV_BOTH, div: '0};
            lvl_prev <= '0;
        end else begin
            lvl_prev <= lvl;
            if (clr_act)
                cfg_q <= sw_cfg;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic ch_hold;
        if (ch == CH_A) begin : g_a
            assign ch_hold = clr_act;
        end else begin : g_b
            assign ch_hold = clr_act | (cur_mode != QM_DIV_BOTH);
        end
        qdiv_pulse_div #(.DIV_W(DIV_W)) u_div (
            .clk(clk), .rst(rst), .hold(ch_hold),
            .lvl(lvl[ch]), .rise(rise[ch]), .div(cur_div),
            .out_q(div_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr_act) begin
            dir_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            ext_q <= lvl[CH_B];
            if (a_rise)
                dir_q <= lvl[CH_B];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) z_q <= 1'b0;
        else     z_q <= enc_s[2];
    end

    always_comb begin
        unique case (cur_mode)
            QM_QUAD_DIR: out_b = dir_q;
            QM_EXT_DIR:  out_b = ext_q;
            default:     out_b = div_out[CH_B];
        endcase
    end

    assign out_a = div_out[CH_A];
    assign out_z = z_q;
endmodule

// File: rtl/qdiv_checker.sv
module qdiv_checker
    import qdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_act,
    input logic             a_rise,
    input qmode_e           cur_mode,
    input logic [DIV_W-1:0] cur_div,
    input logic             enc_a,
    input logic             enc_b,
    input logic             enc_z,
    input logic             out_a,
    input logic             out_b,
    input logic             out_z
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (!out_a && !out_b)); // R2

    AST_ZERO_DIV_LOW: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && cur_div == '0) |=> !out_a); // R7

    AST_MIRROR_N1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && !clr_act && cur_div == DIV_W'(1)) |=> (out_a == $past(enc_a, 3))); // R6

    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == QM_QUAD_DIR && !clr_act && !a_rise) |=> $stable(out_b)); // R8

    AST_EXT_COPY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && cur_mode == QM_EXT_DIR && !clr_act) |=> (out_b == $past(enc_b, 3))); // R9

    AST_INDEX_COPY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_z == $past(enc_z, 3))); // R10
endmodule

bind qenc_divider qdiv_checker u_chk (
    .clk(clk), .rst(rst), .clr_act(clr_act), .a_rise(a_rise),
    .cur_mode(cur_mode), .cur_div(cur_div),
    .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .out_a(out_a), .out_b(out_b), .out_z(out_z)
);

// File: tb/qenc_divider_tb.sv
module qenc_divider_tb;
    import qdiv_pkg::*;

    typedef struct {
        logic  a;
        logic  b;
        logic  z;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [SW_W-1:0] sw_on = '0;
    logic            enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
    logic            out_a, out_b, out_z;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    event chk_ev;

    // bench model state
    int   m_n = 0;
    int   m_mode = 0;
    bit   m_clr = 0;
    bit   m_pa = 0, m_pb = 0;
    int   m_ca = 0, m_cb = 0;
    bit   m_oa = 0, m_ob = 0, m_dir = 0;

    always #10 clk = ~clk;

    qenc_divider u_dut (
        .clk(clk), .rst(rst), .sw_on(sw_on),
        .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .out_a(out_a), .out_b(out_b), .out_z(out_z)
    );

    task automatic check(input logic act, input logic expv, input string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", what, act, expv);
        end
    endtask

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(out_a, e.a, {e.req, " out_a"});
                check(out_b, e.b, {e.req, " out_b"});
                check(out_z, e.z, {e.req, " out_z"});
            end
        end
    end

    task automatic set_sw(input int div, input bit p2, input bit p3, input bit run, input bit rsv);
        logic [SW_W-1:0] lv;
        lv = '0;
        lv[0] = rsv;
        lv[1] = p2;
        lv[2] = p3;
        lv[3] = run;
        lv[11:4] = div[7:0];
        sw_on = ~lv;
    endtask

    function automatic bit step_div(inout int cnt, input int n);
        bit o;
        o = (cnt < n / 2);
        cnt = (cnt >= n - 1) ? 0 : cnt + 1;
        return o;
    endfunction

    task automatic apply(input bit a, input bit b, input bit z, input string req);
        exp_t e;
        bit ra, rb;
        @(negedge clk);
        enc_a = a; enc_b = b; enc_z = z;
        ra = a & ~m_pa;
        rb = b & ~m_pb;
        m_pa = a; m_pb = b;
        if (m_clr) begin
            m_ca = 0; m_cb = 0; m_oa = 0; m_ob = 0; m_dir = 0;
            e.a = 0; e.b = 0;
        end else begin
            if (m_n >= 2 && ra) m_oa = step_div(m_ca, m_n);
            if (m_mode == 0 && m_n >= 2 && rb) m_ob = step_div(m_cb, m_n);
            if (m_mode == 1 && ra) m_dir = b;
            e.a = (m_n == 0) ? 1'b0 : (m_n == 1) ? a : m_oa;
            case (m_mode)
                1:       e.b = m_dir;
                2:       e.b = b;
                default: e.b = (m_n == 0) ? 1'b0 : (m_n == 1) ? b : m_ob;
            endcase
        end
        e.z = z;
        e.req = req;
        repeat (4) @(posedge clk);
        @(negedge clk);
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic do_clear(input int div, input bit p2, input bit p3, input bit rsv);
        @(negedge clk);
        set_sw(div, p2, p3, 1'b0, rsv);
        m_clr = 1;
        apply(enc_a, enc_b, enc_z, "R2 clear");
        apply(enc_a, enc_b, enc_z, "R2 clear");
        @(negedge clk);
        set_sw(div, p2, p3, 1'b1, rsv);
        m_clr = 0;
        m_n = div;
        m_mode = p2 ? 2 : (p3 ? 1 : 0);
        m_ca = 0; m_cb = 0; m_oa = 0; m_ob = 0; m_dir = 0;
        repeat (6) @(posedge clk);
    endtask

    task automatic pulse_a(input int k, input string req);
        for (int i = 0; i < k; i++) begin
            apply(1'b1, enc_b, enc_z, req);
            apply(1'b0, enc_b, enc_z, req);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        set_sw(0, 0, 0, 1, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        check(out_a, 1'b0, "R2 reset out_a");
        check(out_b, 1'b0, "R2 reset out_b");
        check(out_z, 1'b0, "R2 reset out_z");

        // R4 R5: both channels divided by 4, A and B interleaved
        do_clear(4, 0, 0, 0);
        for (int i = 0; i < 10; i++) begin
            apply(1, 0, 0, "R4 div4");
            apply(1, 1, 0, "R4 div4");
            apply(0, 1, 0, "R5 div4");
            apply(0, 0, 0, "R5 div4");
        end
        // R5 odd denominator, B alone then A alone
        do_clear(3, 0, 0, 0);
        for (int i = 0; i < 7; i++) begin
            apply(0, 1, 0, "R5 div3 b");
            apply(0, 0, 0, "R5 div3 b");
        end
        pulse_a(7, "R5 div3 a");

        // R6 mirror
        do_clear(1, 0, 0, 0);
        apply(1, 0, 0, "R6 n1");
        apply(1, 1, 0, "R6 n1");
        apply(0, 1, 0, "R6 n1");
        apply(0, 0, 0, "R6 n1");

        // R7 zero denominator
        do_clear(0, 0, 0, 0);
        pulse_a(3, "R7 n0");
        apply(0, 1, 0, "R7 n0");
        apply(0, 0, 0, "R7 n0");

        // R1 R11: worked pattern (N=85), unused position set
        do_clear(85, 0, 0, 1);
        pulse_a(90, "R1 n85");
        // R11: same with unused position toggled while running
        set_sw(85, 0, 0, 1, 0);
        pulse_a(4, "R11 rsv");

        // R3: capture N=2, then rewrite to N=5 while running
        do_clear(2, 0, 0, 0);
        set_sw(5, 0, 0, 1, 0);
        repeat (4) @(posedge clk);
        pulse_a(6, "R3 no effect");

        // R8 quadrature direction
        do_clear(2, 0, 1, 0);
        for (int i = 0; i < 3; i++) begin
            apply(1, 0, 0, "R8 a leads");
            apply(1, 1, 0, "R8 a leads");
            apply(0, 1, 0, "R8 a leads");
            apply(0, 0, 0, "R8 a leads");
        end
        for (int i = 0; i < 3; i++) begin
            apply(0, 1, 0, "R8 b leads");
            apply(1, 1, 0, "R8 b leads");
            apply(1, 0, 0, "R8 b leads");
            apply(0, 0, 0, "R8 b leads");
        end

        // R9 external direction, position 3 both ways
        do_clear(2, 1, 1, 0);
        apply(1, 1, 0, "R9 ext");
        apply(0, 1, 0, "R9 ext");
        apply(0, 0, 0, "R9 ext");
        apply(1, 0, 0, "R9 ext");
        do_clear(3, 1, 0, 0);
        apply(0, 1, 0, "R9 ext");
        apply(1, 1, 0, "R9 ext");
        apply(0, 0, 0, "R9 ext");

        // R10 index pass-through, running and during clear
        apply(0, 0, 1, "R10 z");
        apply(0, 0, 0, "R10 z");
        @(negedge clk);
        set_sw(3, 1, 0, 0, 0);
        m_clr = 1;
        apply(1, 0, 1, "R10 z clr");
        apply(0, 1, 0, "R2 clr");
        apply(1, 1, 1, "R10 z clr");
        apply(0, 0, 0, "R2 clr");

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule